// File: doc/BRIEF.md
# Hashed Inverted Page Table Walker

This block turns a virtual page number and a process identifier into a physical frame number. It searches a table that has exactly one slot per physical frame. The table size is therefore set by how much real memory exists, not by how many processes are running. Each slot records which virtual page of which process currently lives in that frame. It also holds a valid bit, a modified bit and a link to another slot. A fold of the page number selects the first slot to inspect. When that slot belongs to some other page, the walker follows the links one slot per clock until it finds the owner or the chain runs out. The frame number is never stored. It is the position of the slot that matched, and the real address is that position placed above the untouched page offset.

Software or a fault handler fills the table through a single-entry write port. Translation requests enter on a valid/ready channel and results leave on a second valid/ready channel. The request side accepts only while the walker is idle, so `req_ready` stays low from acceptance until the response has been taken. A response that is not taken stays put with all its fields frozen until `rsp_ready` is high at a clock edge. A request is accepted at an edge where both `req_valid` and `req_ready` are high. Choosing a victim frame and servicing a fault are left to the surrounding logic.

Top module: `ipt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and every table slot has its valid bit and its link-enable bit cleared.
- R2: The first slot examined is the XOR of the page number split into M-bit pieces, starting at bit 0, with the top piece zero-padded.
- R3: A slot matches only when its valid bit is 1 and both its stored page number and its process identifier equal the request. A match gives `rsp_fault`=0 and `rsp_addr` = {slot index (upper M bits), request offset (lower OFF_W bits)}.
- R4: When the examined slot does not match and its link-enable bit is 1, the next slot examined is the one named by its link field.
- R5: When the examined slot does not match and its link-enable bit is 0, the response has `rsp_fault`=1, `rsp_addr`=0 and `rsp_dirty`=0.
- R6: Exactly one slot is examined per clock. A request whose result comes from the k-th slot examined raises `rsp_valid` k clock edges after the edge that accepted it.
- R7: A walk stops with a fault after 2^M slots have been examined without a match. A match found on the 2^M-th slot is still reported as a hit.
- R8: `req_ready` is 0 from the accepting edge until the response has been taken, and a request is accepted only at an edge where `req_valid` and `req_ready` are both 1.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response holds `rsp_valid`, `rsp_fault`, `rsp_addr` and `rsp_dirty` unchanged. `req_ready` returns to 1 on the edge that completes the response handshake.
- R10: On a hit, `rsp_dirty` is the modified bit of the matching slot. The modified bit has no effect on whether a slot matches.
- R11: A table write with `tbl_wr_en`=1 replaces all fields of slot `tbl_wr_idx` at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vpn | input | VPN_W | Virtual page number |
| req_pid | input | PID_W | Process identifier |
| req_off | input | OFF_W | Page offset |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 1 | No owning slot was found |
| rsp_addr | output | M+OFF_W | Real address {frame, offset}; zero on fault |
| rsp_dirty | output | 1 | Modified bit of the matching slot |
| tbl_wr_en | input | 1 | Write one table slot |
| tbl_wr_idx | input | M | Slot to write (frame number) |
| tbl_wr_vpn | input | VPN_W | Page number to store |
| tbl_wr_pid | input | PID_W | Process identifier to store |
| tbl_wr_valid | input | 1 | Valid bit to store |
| tbl_wr_dirty | input | 1 | Modified bit to store |
| tbl_wr_link_en | input | 1 | Link-enable bit to store |
| tbl_wr_link | input | M | Link to the next slot |

## Verification
The translation is exercised with several request patterns. A request that hits at its hashed slot checks the fold and the address layout. A two-slot chain checks that links are followed and that the frame comes from the slot's position, not from the hash. A hit slot with the modified bit set checks that `rsp_dirty` reports it. Requests that differ only in process identifier, or that hit a slot whose valid bit is clear, confirm that both keys and the valid bit gate a match. A chain that ends early separates the end-of-chain fault from a hit. A fully circular chain with no owner forces the step limit. The same ring with the owner placed last shows the limit does not swallow a hit on the final step. Latency is counted for every request to confirm one slot per clock. A held response checks back-pressure.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_RESP = 2'd2
  } walk_state_t;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int M     = 3,
  parameter int VPN_W = 8
) (
  input  logic [VPN_W-1:0] vpn,
  output logic [M-1:0]     idx
);
  localparam int PIECES = (VPN_W + M - 1) / M;
  localparam int PAD_W  = PIECES * M;

  logic [PAD_W-1:0] padded;
  logic [M-1:0]     partial [PIECES+1];

  assign padded     = PAD_W'(vpn);
  assign partial[0] = '0;

  for (genvar g = 0; g < PIECES; g++) begin : g_fold
    assign partial[g+1] = partial[g] ^ padded[g*M +: M];
  end

  assign idx = partial[PIECES];
endmodule

// File: rtl/ipt_table.sv
module ipt_table #(
  parameter int M     = 3,
  parameter int VPN_W = 8,
  parameter int PID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [M-1:0]     wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PID_W-1:0] wr_pid,
  input  logic             wr_valid,
  input  logic             wr_dirty,
  input  logic             wr_link_en,
  input  logic [M-1:0]     wr_link,
  input  logic [M-1:0]     rd_idx,
  output logic [VPN_W-1:0] rd_vpn,
  output logic [PID_W-1:0] rd_pid,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic             rd_link_en,
  output logic [M-1:0]     rd_link
);
  localparam int DEPTH = 1 << M;

  logic [VPN_W-1:0] vpn_r     [DEPTH];
  logic [PID_W-1:0] pid_r     [DEPTH];
  logic             valid_r   [DEPTH];
  logic             dirty_r   [DEPTH];
  logic             link_en_r [DEPTH];
  logic [M-1:0]     link_r    [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        vpn_r[i]     <= '0;
        pid_r[i]     <= '0;
        valid_r[i]   <= 1'b0;
        dirty_r[i]   <= 1'b0;
        link_en_r[i] <= 1'b0;
        link_r[i]    <= '0;
      end
    end else if (wr_en) begin
      vpn_r[wr_idx]     <= wr_vpn;
      pid_r[wr_idx]     <= wr_pid;
      valid_r[wr_idx]   <= wr_valid;
      dirty_r[wr_idx]   <= wr_dirty;
      link_en_r[wr_idx] <= wr_link_en;
      link_r[wr_idx]    <= wr_link;
    end
  end

  assign rd_vpn     = vpn_r[rd_idx];
  assign rd_pid     = pid_r[rd_idx];
  assign rd_valid   = valid_r[rd_idx];
  assign rd_dirty   = dirty_r[rd_idx];
  assign rd_link_en = link_en_r[rd_idx];
  assign rd_link    = link_r[rd_idx];
endmodule

// File: rtl/ipt_walk_ctrl.sv
module ipt_walk_ctrl
  import ipt_pkg::*;
#(
  parameter int M     = 3,
  parameter int VPN_W = 8,
  parameter int PID_W = 4,
  parameter int OFF_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [PID_W-1:0]   req_pid,
  input  logic [OFF_W-1:0]   req_off,
  input  logic [M-1:0]       start_idx,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_fault,
  output logic [M+OFF_W-1:0] rsp_addr,
  output logic               rsp_dirty,
  output logic [M-1:0]       rd_idx,
  input  logic [VPN_W-1:0]   ent_vpn,
  input  logic [PID_W-1:0]   ent_pid,
  input  logic               ent_valid,
  input  logic               ent_dirty,
  input  logic               ent_link_en,
  input  logic [M-1:0]       ent_link
);
  localparam logic [M-1:0] LAST_STEP = {M{1'b1}};

  walk_state_t      state;
  logic [M-1:0]     cur_q;
  logic [M-1:0]     steps_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PID_W-1:0] pid_q;
  logic [OFF_W-1:0] off_q;
  logic             fault_q;
  logic             dirty_q;
  logic             hit;

  assign hit = ent_valid && (ent_vpn == vpn_q) && (ent_pid == pid_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur_q   <= '0;
      steps_q <= '0;
      vpn_q   <= '0;
      pid_q   <= '0;
      off_q   <= '0;
      fault_q <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            vpn_q   <= req_vpn;
            pid_q   <= req_pid;
            off_q   <= req_off;
            cur_q   <= start_idx;
            steps_q <= '0;
            state   <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (hit) begin
            fault_q <= 1'b0;
            dirty_q <= ent_dirty;
            state   <= ST_RESP;
          end else if (!ent_link_en || steps_q == LAST_STEP) begin
            fault_q <= 1'b1;
            dirty_q <= 1'b0;
            state   <= ST_RESP;
          end else begin
            cur_q   <= ent_link;
            steps_q <= steps_q + 1'b1;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_fault = fault_q;
  assign rsp_dirty = dirty_q;
  assign rsp_addr  = fault_q ? '0 : {cur_q, off_q};
  assign rd_idx    = cur_q;
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker #(
  parameter int M     = 3,
  parameter int VPN_W = 8,
  parameter int PID_W = 4,
  parameter int OFF_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [PID_W-1:0]   req_pid,
  input  logic [OFF_W-1:0]   req_off,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_fault,
  output logic [M+OFF_W-1:0] rsp_addr,
  output logic               rsp_dirty,
  input  logic               tbl_wr_en,
  input  logic [M-1:0]       tbl_wr_idx,
  input  logic [VPN_W-1:0]   tbl_wr_vpn,
  input  logic [PID_W-1:0]   tbl_wr_pid,
  input  logic               tbl_wr_valid,
  input  logic               tbl_wr_dirty,
  input  logic               tbl_wr_link_en,
  input  logic [M-1:0]       tbl_wr_link
);
  logic [M-1:0]     start_idx;
  logic [M-1:0]     rd_idx;
  logic [VPN_W-1:0] ent_vpn;
  logic [PID_W-1:0] ent_pid;
  logic             ent_valid;
  logic             ent_dirty;
  logic             ent_link_en;
  logic [M-1:0]     ent_link;

  ipt_hash #(.M(M), .VPN_W(VPN_W)) u_hash (
    .vpn (req_vpn),
    .idx (start_idx)
  );

  ipt_table #(.M(M), .VPN_W(VPN_W), .PID_W(PID_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (tbl_wr_en),
    .wr_idx     (tbl_wr_idx),
    .wr_vpn     (tbl_wr_vpn),
    .wr_pid     (tbl_wr_pid),
    .wr_valid   (tbl_wr_valid),
    .wr_dirty   (tbl_wr_dirty),
    .wr_link_en (tbl_wr_link_en),
    .wr_link    (tbl_wr_link),
    .rd_idx     (rd_idx),
    .rd_vpn     (ent_vpn),
    .rd_pid     (ent_pid),
    .rd_valid   (ent_valid),
    .rd_dirty   (ent_dirty),
    .rd_link_en (ent_link_en),
    .rd_link    (ent_link)
  );

  ipt_walk_ctrl #(.M(M), .VPN_W(VPN_W), .PID_W(PID_W), .OFF_W(OFF_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vpn     (req_vpn),
    .req_pid     (req_pid),
    .req_off     (req_off),
    .start_idx   (start_idx),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_fault   (rsp_fault),
    .rsp_addr    (rsp_addr),
    .rsp_dirty   (rsp_dirty),
    .rd_idx      (rd_idx),
    .ent_vpn     (ent_vpn),
    .ent_pid     (ent_pid),
    .ent_valid   (ent_valid),
    .ent_dirty   (ent_dirty),
    .ent_link_en (ent_link_en),
    .ent_link    (ent_link)
  );
endmodule

// File: rtl/ipt_walker_chk.sv
module ipt_walker_chk #(
  parameter int M     = 3,
  parameter int OFF_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [OFF_W-1:0]   req_off,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_fault,
  input logic [M+OFF_W-1:0] rsp_addr,
  input logic               rsp_dirty
);
  localparam int CNT_W = M + 2;
  localparam logic [CNT_W-1:0] MAX_BUSY = CNT_W'(1 << M);

  logic [CNT_W-1:0] busy_cnt;
  logic [OFF_W-1:0] off_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      off_seen <= '0;
    end else begin
      if (req_valid && req_ready) off_seen <= req_off;
      if (!req_ready && !rsp_valid) busy_cnt <= busy_cnt + 1'b1;
      else busy_cnt <= '0;
    end
  end

  // R8
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault)
                                   && $stable(rsp_addr) && $stable(rsp_dirty)));

  // R6
  no_same_cycle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !rsp_valid);

  // R7
  walk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= MAX_BUSY);

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_addr[OFF_W-1:0] == off_seen));
endmodule

bind ipt_walker ipt_walker_chk #(.M(M), .OFF_W(OFF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_off   (req_off),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_fault (rsp_fault),
  .rsp_addr  (rsp_addr),
  .rsp_dirty (rsp_dirty)
);

// File: tb/ipt_walker_test.sv
module ipt_walker_test;
  localparam int M     = 3;
  localparam int VPN_W = 8;
  localparam int PID_W = 4;
  localparam int OFF_W = 4;
  localparam int AW    = M + OFF_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [VPN_W-1:0] req_vpn = '0;
  logic [PID_W-1:0] req_pid = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic rsp_fault;
  logic [AW-1:0] rsp_addr;
  logic rsp_dirty;
  logic tbl_wr_en = 1'b0;
  logic [M-1:0] tbl_wr_idx = '0;
  logic [VPN_W-1:0] tbl_wr_vpn = '0;
  logic [PID_W-1:0] tbl_wr_pid = '0;
  logic tbl_wr_valid = 1'b0;
  logic tbl_wr_dirty = 1'b0;
  logic tbl_wr_link_en = 1'b0;
  logic [M-1:0] tbl_wr_link = '0;

  int checks = 0;
  int failures = 0;
  logic r_fault;
  logic r_dirty;
  logic [AW-1:0] r_addr;
  int r_lat;

  always #5 clk = ~clk;

  ipt_walker #(.M(M), .VPN_W(VPN_W), .PID_W(PID_W), .OFF_W(OFF_W)) uut (.*);

  function automatic logic [M-1:0] fold(input logic [VPN_W-1:0] v);
    logic [M-1:0] h = '0;
    for (int i = 0; i < VPN_W; i++) h[i % M] = h[i % M] ^ v[i];
    return h;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int idx, input int vpn, input int pid, input bit vld,
                     input bit dty, input bit len, input int lnk);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_idx = M'(idx); tbl_wr_vpn = VPN_W'(vpn);
    tbl_wr_pid = PID_W'(pid); tbl_wr_valid = vld; tbl_wr_dirty = dty;
    tbl_wr_link_en = len; tbl_wr_link = M'(lnk);
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic translate(input int vpn, input int pid, input int off);
    @(negedge clk);
    req_vpn = VPN_W'(vpn); req_pid = PID_W'(pid); req_off = OFF_W'(off);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 1;
    while (!rsp_valid && r_lat < 40) begin
      @(negedge clk);
      r_lat++;
    end
    r_fault = rsp_fault; r_addr = rsp_addr; r_dirty = rsp_dirty;
  endtask

  task automatic t_reset;
    check("R1 req_ready", 32'(req_ready), 1);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    translate(0, 0, 3);
    check("R1 empty table faults", 32'(r_fault), 1);
  endtask

  task automatic t_direct_hit;
    check("R2 fold of 0x05", 32'(fold(8'h05)), 5);
    put(5, 8'h05, 2, 1, 1, 0, 0);
    translate(8'h05, 2, 4'hA);
    check("R3 hit fault", 32'(r_fault), 0);
    check("R3 hit addr", 32'(r_addr), 32'h5A);
    check("R10 dirty reported", 32'(r_dirty), 1);
    check("R6 latency one slot", r_lat, 2);
  endtask

  task automatic t_chain_hit;
    check("R2 fold of 0x0D", 32'(fold(8'h0D)), 4);
    put(4, 8'h30, 1, 1, 0, 1, 6);
    put(6, 8'h0D, 3, 1, 0, 0, 0);
    translate(8'h0D, 3, 4'h7);
    check("R4 chained hit fault", 32'(r_fault), 0);
    check("R4 frame is slot index", 32'(r_addr), 32'h67);
    check("R10 clean slot", 32'(r_dirty), 0);
    check("R6 latency two slots", r_lat, 3);
  endtask

  task automatic t_key_mismatch;
    translate(8'h05, 7, 4'h1);
    check("R3 pid mismatch faults", 32'(r_fault), 1);
    check("R5 fault addr zero", 32'(r_addr), 0);
    check("R5 fault dirty zero", 32'(r_dirty), 0);
    put(5, 8'h05, 2, 0, 0, 0, 0);
    translate(8'h05, 2, 4'h1);
    check("R3 invalid slot never matches", 32'(r_fault), 1);
  endtask

  task automatic t_chain_end;
    put(6, 8'h44, 3, 1, 0, 0, 0);
    translate(8'h0D, 3, 4'h2);
    check("R5 chain end faults", 32'(r_fault), 1);
    check("R5 chain end latency", r_lat, 3);
  endtask

  task automatic t_ring;
    for (int i = 0; i < 8; i++) put(i, 8'h80 + i, 9, 1, 0, 1, (i + 1) % 8);
    translate(8'h00, 0, 4'h3);
    check("R7 ring aborts with fault", 32'(r_fault), 1);
    check("R7 ring latency", r_lat, 9);
    put(7, 8'h00, 0, 1, 0, 1, 0);
    translate(8'h00, 0, 4'hC);
    check("R7 hit on last step", 32'(r_fault), 0);
    check("R7 last step addr", 32'(r_addr), 32'h7C);
    check("R7 last step latency", r_lat, 9);
  endtask

  task automatic t_backpressure;
    logic [AW-1:0] held;
    put(5, 8'h05, 2, 1, 0, 0, 0);
    rsp_ready = 1'b0;
    translate(8'h05, 2, 4'hE);
    held = r_addr;
    check("R11 rewritten slot hits", 32'(held), 32'h5E);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 valid held", 32'(rsp_valid), 1);
      check("R9 addr held", 32'(rsp_addr), 32'(held));
      check("R8 not ready while busy", 32'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 released", 32'(rsp_valid), 0);
    check("R9 ready returns", 32'(req_ready), 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct_hit();
        t_chain_hit();
        t_key_mismatch();
        t_chain_end();
        t_ring();
        t_backpressure();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule